// File: doc/BRIEF.md
# SPI Digital Potentiometer Command Controller

This block is the digital core of a 1024-position resistor ladder that is controlled over SPI. A host sends 16-bit frames. Each frame carries a 4-bit command and a 10-bit data field. The block keeps the wiper code, a 4-bit control register and a shutdown flag. It also models a small one-time-programmable store of wiper codes. That store can only be appended to, and reset reloads the wiper from its newest entry.

Read commands do not return data in the frame that issues them. They stage a 16-bit response, and the block shifts that response out on the serial output during the following frame. A typical host therefore follows a read with a no-op frame.

The SPI pins are oversampled in the system clock domain through a synchronizer. Commands take effect when chip select rises. The serial output comes with its own output-enable pin for the pad ring. `rst_n` acts as the power-on reset. It also empties the modelled store.

Top module: `dpot_spi_ctrl`

## Requirements
- R1: A frame holds a command in bits 13:10 and data in bits 9:0, and bits 15:14 are not decoded. Command 1 copies the data field into `wiper_code` when control bit 1 is set. For example, frame 0x0500 sets the wiper to 0x100.
- R2: While control bit 1 is clear, command 1 leaves `wiper_code` unchanged.
- R3: After power-on reset, `wiper_code` is 0x200, `shutdown` is 0, `cal_en` is 1, and the control register reads 0.
- R4: Command 7 loads control bits 2:0 from data bits 2:0. Control bit 3 is not writable by command 7. `cal_en` is the inverse of control bit 2.
- R5: When control bit 0 is set and a slot is free, command 3 appends the current wiper to the next slot (slots fill from index 0 upward) and sets control bit 3. Otherwise it stores nothing and clears control bit 3. The fill count never exceeds SLOTS.
- R6: Commands 2, 5, 6 and 8 stage, right-aligned in a 16-bit word, one of four values:
  - command 2: the wiper;
  - command 5: the slot indexed by the data field, or 0 when that index is at or beyond SLOTS;
  - command 6: the index of the newest slot, or 0 when the store is empty;
  - command 8: the control register.
- R7: Every other accepted command stages 0. The staged word leaves MSB first during the next frame, and the host samples it on the rising SCLK edges.
- R8: Command 9 sets `shutdown` to data bit 0.
- R9: Command 4 loads the wiper from the newest slot, or 0x200 if the store is empty. It clears `shutdown` and leaves the control register unchanged.
- R10: A frame in which the number of SCLK rising edges with chip select low is not 16 changes no state. The staged response is kept for the next frame.
- R11: `spi_miso_en` is 0 while `spi_cs_n` is high and 1 while it is low.
- R12: Commands execute normally while `shutdown` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low power-on reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data in, sampled on SCLK rise |
| spi_miso | output | 1 | Serial data out, changes after SCLK fall |
| spi_miso_en | output | 1 | Output enable for the serial data pad |
| wiper_code | output | 10 | Current wiper position |
| shutdown | output | 1 | Ladder shut down (A terminal open) |
| cal_en | output | 1 | Resistor tolerance calibration enabled |

## Verification
The bench builds the block with SLOTS set to 6, so filling the store and the failed append that follows take only a few frames. The synchronizer depth stays at 2. With only six slots, the bench can reach the exhaustion corner, the newest-slot address read, and an out-of-range slot read. The bench also runs discarded 15-bit and 17-bit frames and the one-frame read latency against an independent model.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  localparam int FRAME_BITS = 16;
  localparam int CMD_BITS   = 4;
  localparam int DATA_BITS  = 10;

  typedef enum logic [CMD_BITS-1:0] {
    OP_NOP      = 4'd0,
    OP_WR_WIPER = 4'd1,
    OP_RD_WIPER = 4'd2,
    OP_STORE    = 4'd3,
    OP_RELOAD   = 4'd4,
    OP_RD_SLOT  = 4'd5,
    OP_RD_LAST  = 4'd6,
    OP_WR_CTRL  = 4'd7,
    OP_RD_CTRL  = 4'd8,
    OP_SLEEP    = 4'd9
  } dpot_op_e;

  // Control register bit positions (decoded by the command core).
  localparam int CB_PROG_EN = 0;
  localparam int CB_WR_EN   = 1;
  localparam int CB_CAL_OFF = 2;
  localparam int CB_PROG_OK = 3;

  function automatic logic [CMD_BITS-1:0] op_of(input logic [FRAME_BITS-1:0] w);
    return w[DATA_BITS +: CMD_BITS];
  endfunction

  function automatic logic [DATA_BITS-1:0] arg_of(input logic [FRAME_BITS-1:0] w);
    return w[DATA_BITS-1:0];
  endfunction

  function automatic logic [DATA_BITS-1:0] mid_code();
    return {1'b1, {(DATA_BITS-1){1'b0}}};
  endfunction

endpackage

// File: rtl/dpot_spi_front.sv
module dpot_spi_front #(
  parameter int FRAME_W = 16,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               mosi,
  input  logic [FRAME_W-1:0] resp,
  output logic               frame_ok,
  output logic [FRAME_W-1:0] frame_word,
  output logic               sdo_bit
);
  localparam int CNT_W = $clog2(FRAME_W + 2);

  logic [SYNC_N-1:0] cs_pipe, sclk_pipe, mosi_pipe;
  logic cs_s, sclk_s, mosi_s, cs_d, sclk_d;
  logic sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] rx_q, tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe   <= '1;
      sclk_pipe <= '0;
      mosi_pipe <= '0;
      cs_d      <= 1'b1;
      sclk_d    <= 1'b0;
    end else begin
      cs_pipe   <= {cs_pipe[SYNC_N-2:0], cs_n};
      sclk_pipe <= {sclk_pipe[SYNC_N-2:0], sclk};
      mosi_pipe <= {mosi_pipe[SYNC_N-2:0], mosi};
      cs_d      <= cs_s;
      sclk_d    <= sclk_s;
    end
  end

  assign cs_s      = cs_pipe[SYNC_N-1];
  assign sclk_s    = sclk_pipe[SYNC_N-1];
  assign mosi_s    = mosi_pipe[SYNC_N-1];
  assign sclk_rise = sclk_s & ~sclk_d & ~cs_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_s;
  assign cs_fall   = ~cs_s & cs_d;
  assign cs_rise   = cs_s & ~cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_q    <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      rx_q <= {rx_q[FRAME_W-2:0], mosi_s};
      if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_q <= '0;
    else if (cs_fall)   tx_q <= resp;
    else if (sclk_fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
  end

  assign frame_ok   = cs_rise & (bit_cnt == CNT_W'(FRAME_W));
  assign frame_word = rx_q;
  assign sdo_bit    = tx_q[FRAME_W-1];
endmodule

// File: rtl/dpot_otp_store.sv
module dpot_otp_store #(
  parameter int SLOTS  = 50,
  parameter int DATA_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       prog_req,
  input  logic [DATA_W-1:0]          prog_data,
  input  logic [DATA_W-1:0]          rd_index,
  output logic [DATA_W-1:0]          rd_data,
  output logic [DATA_W-1:0]          newest_data,
  output logic [$clog2(SLOTS)-1:0]   newest_index,
  output logic [$clog2(SLOTS+1)-1:0] fill_count,
  output logic                       is_full,
  output logic                       is_empty
);
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam int IDX_W = $clog2(SLOTS);

  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_go;

  assign is_full  = (cnt_q == CNT_W'(SLOTS));
  assign is_empty = (cnt_q == '0);
  assign wr_go    = prog_req & ~is_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wr_go) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [DATA_W-1:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 cell_q <= '0;
      else if (wr_go && cnt_q == CNT_W'(g))       cell_q <= prog_data;
    end
    assign slot_q[g] = cell_q;
  end

  always_comb begin
    rd_data     = '0;
    newest_data = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (rd_index == DATA_W'(i))   rd_data     = slot_q[i];
      if (cnt_q == CNT_W'(i + 1))   newest_data = slot_q[i];
    end
  end

  assign newest_index = is_empty ? '0 : IDX_W'(cnt_q - 1'b1);
  assign fill_count   = cnt_q;
endmodule

// File: rtl/dpot_cmd_core.sv
module dpot_cmd_core
  import dpot_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int DATA_W  = 10,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec,
  input  logic [3:0]         op,
  input  logic [DATA_W-1:0]  arg,
  input  logic               otp_full,
  input  logic               otp_empty,
  input  logic [DATA_W-1:0]  otp_newest,
  input  logic [IDX_W-1:0]   otp_newest_idx,
  input  logic [DATA_W-1:0]  otp_rd_data,
  output logic               prog_req,
  output logic [DATA_W-1:0]  wiper,
  output logic [3:0]         ctrl,
  output logic               asleep,
  output logic [FRAME_W-1:0] resp
);
  logic [FRAME_W-1:0] resp_next;
  logic [DATA_W-1:0]  reload_val;

  assign reload_val = otp_empty ? {1'b1, {(DATA_W-1){1'b0}}} : otp_newest;
  assign prog_req   = exec && (op == OP_STORE) && ctrl[CB_PROG_EN] && !otp_full;

  always_comb begin
    unique case (op)
      OP_RD_WIPER: resp_next = FRAME_W'(wiper);
      OP_RD_SLOT:  resp_next = FRAME_W'(otp_rd_data);
      OP_RD_LAST:  resp_next = FRAME_W'(otp_newest_idx);
      OP_RD_CTRL:  resp_next = FRAME_W'(ctrl);
      default:     resp_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper  <= {1'b1, {(DATA_W-1){1'b0}}};
      ctrl   <= '0;
      asleep <= 1'b0;
      resp   <= '0;
    end else if (exec) begin
      resp <= resp_next;
      unique case (op)
        OP_WR_WIPER: if (ctrl[CB_WR_EN]) wiper <= arg;
        OP_STORE:    ctrl[CB_PROG_OK] <= ctrl[CB_PROG_EN] && !otp_full;
        OP_RELOAD: begin
          wiper  <= reload_val;
          asleep <= 1'b0;
        end
        OP_WR_CTRL:  ctrl[CB_CAL_OFF:CB_PROG_EN] <= arg[2:0];
        OP_SLEEP:    asleep <= arg[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dpot_spi_ctrl.sv
module dpot_spi_ctrl
  import dpot_pkg::*;
#(
  parameter int FRAME_W = dpot_pkg::FRAME_BITS,
  parameter int DATA_W  = dpot_pkg::DATA_BITS,
  parameter int SLOTS   = 50,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_en,
  output logic [DATA_W-1:0] wiper_code,
  output logic              shutdown,
  output logic              cal_en
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam int CNT_W = $clog2(SLOTS + 1);

  // Named internal events, observed by the bound checker.
  logic               exec_evt;
  logic [FRAME_W-1:0] frame_word;
  logic [3:0]         op_evt;
  logic [DATA_W-1:0]  arg_evt;
  logic               prog_evt;
  logic [3:0]         ctrl_q;
  logic [CNT_W-1:0]   otp_count;

  logic [FRAME_W-1:0] resp_q;
  logic               sdo_bit;
  logic [DATA_W-1:0]  otp_rd_data, otp_newest;
  logic [IDX_W-1:0]   otp_newest_idx;
  logic               otp_full, otp_empty;

  assign op_evt  = op_of(frame_word);
  assign arg_evt = arg_of(frame_word);

  dpot_spi_front #(.FRAME_W(FRAME_W), .SYNC_N(SYNC_N)) u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .resp(resp_q), .frame_ok(exec_evt), .frame_word(frame_word), .sdo_bit(sdo_bit)
  );

  dpot_otp_store #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_otp (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_evt), .prog_data(wiper_code),
    .rd_index(arg_evt), .rd_data(otp_rd_data), .newest_data(otp_newest),
    .newest_index(otp_newest_idx), .fill_count(otp_count),
    .is_full(otp_full), .is_empty(otp_empty)
  );

  dpot_cmd_core #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_core (
    .clk(clk), .rst_n(rst_n), .exec(exec_evt), .op(op_evt), .arg(arg_evt),
    .otp_full(otp_full), .otp_empty(otp_empty), .otp_newest(otp_newest),
    .otp_newest_idx(otp_newest_idx), .otp_rd_data(otp_rd_data),
    .prog_req(prog_evt), .wiper(wiper_code), .ctrl(ctrl_q),
    .asleep(shutdown), .resp(resp_q)
  );

  assign spi_miso_en = ~spi_cs_n;
  assign spi_miso    = spi_cs_n ? 1'b0 : sdo_bit;
  assign cal_en      = ~ctrl_q[CB_CAL_OFF];
endmodule

// File: rtl/dpot_spi_ctrl_chk.sv
module dpot_spi_ctrl_chk #(
  parameter int DATA_W = 10,
  parameter int SLOTS  = 50,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exec_evt,
  input logic [3:0]        op_evt,
  input logic [DATA_W-1:0] arg_evt,
  input logic              prog_evt,
  input logic [3:0]        ctrl_q,
  input logic [CNT_W-1:0]  otp_count,
  input logic [DATA_W-1:0] wiper_code,
  input logic              shutdown
);
  a_r1_wiper_written: assert property (@(posedge clk) disable iff (!rst_n)
    exec_evt && op_evt == 4'd1 && ctrl_q[1] |=> wiper_code == $past(arg_evt));

  a_r2_wiper_locked: assert property (@(posedge clk) disable iff (!rst_n)
    exec_evt && op_evt == 4'd1 && !ctrl_q[1] |=> $stable(wiper_code));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    otp_count <= CNT_W'(SLOTS));

  a_r5_prog_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    prog_evt |-> ctrl_q[0]);

  a_r5_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    prog_evt |=> otp_count == $past(otp_count) + 1'b1);

  a_r8_sleep_follows: assert property (@(posedge clk) disable iff (!rst_n)
    exec_evt && op_evt == 4'd9 |=> shutdown == $past(arg_evt[0]));

  a_r9_reload_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    exec_evt && op_evt == 4'd4 |=> !shutdown);

  a_r10_quiet_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_evt |=> $stable(wiper_code) && $stable(shutdown) && $stable(ctrl_q));
endmodule

bind dpot_spi_ctrl dpot_spi_ctrl_chk #(.DATA_W(DATA_W), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_evt(exec_evt), .op_evt(op_evt), .arg_evt(arg_evt),
  .prog_evt(prog_evt), .ctrl_q(ctrl_q), .otp_count(otp_count),
  .wiper_code(wiper_code), .shutdown(shutdown)
);

// File: tb/dpot_spi_ctrl_test.sv
`timescale 1ns/1ps
module dpot_spi_ctrl_test;
  localparam int S    = 6;
  localparam int HALF = 64;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  wire       miso, miso_en, shut, cal;
  wire [9:0] wiper;

  always #4 clk = ~clk;

  dpot_spi_ctrl #(.SLOTS(S)) uut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_en(miso_en), .wiper_code(wiper),
    .shutdown(shut), .cal_en(cal)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] cap;
  event        frame_done;

  // Reference model, written from the requirements.
  int       m_wiper = 512;
  bit [3:0] m_ctrl  = 0;
  bit       m_shut  = 0;
  int       m_otp[S];
  int       m_cnt   = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares each captured response with the queued expectation.
  always @(frame_done) begin
    if (exp_q.size() == 0) check("R7 empty queue", 1, 0);
    else check(tag_q.pop_front(), int'(cap), int'(exp_q.pop_front()));
  end

  task automatic shift(input logic [31:0] w, input int n);
    cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      mosi = w[n-1-i];
      #HALF;
      if (i == 0) check("R11 enable low cs", int'(miso_en), 1);
      cap = {cap[14:0], miso};
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
    end
    #HALF;
    cs_n = 1'b1;
    #(12*8);
    check("R11 enable high cs", int'(miso_en), 0);
  endtask

  task automatic check_ports(string tag);
    check({tag, " wiper"}, int'(wiper), m_wiper);
    check({tag, " shutdown"}, int'(shut), int'(m_shut));
    check({tag, " cal_en"}, int'(cal), int'(!m_ctrl[2]));
  endtask

  // Driver: sends a 16-bit frame, advances the model, queues the next response.
  task automatic send(string tag, input logic [3:0] c, input logic [9:0] d);
    logic [15:0] nx;
    shift({16'h0, 2'b00, c, d}, 16);
    ->frame_done;
    #1;
    case (c)
      4'd2: nx = 16'(m_wiper);
      4'd5: nx = (int'(d) < S) ? 16'(m_otp[d]) : 16'h0;
      4'd6: nx = (m_cnt > 0) ? 16'(m_cnt - 1) : 16'h0;
      4'd8: nx = 16'(m_ctrl);
      default: nx = 16'h0;
    endcase
    case (c)
      4'd1: if (m_ctrl[1]) m_wiper = int'(d);
      4'd3: if (m_ctrl[0] && m_cnt < S) begin
              m_otp[m_cnt] = m_wiper; m_cnt++; m_ctrl[3] = 1'b1;
            end else m_ctrl[3] = 1'b0;
      4'd4: begin m_wiper = (m_cnt > 0) ? m_otp[m_cnt-1] : 512; m_shut = 0; end
      4'd7: m_ctrl[2:0] = d[2:0];
      4'd9: m_shut = d[0];
      default: ;
    endcase
    exp_q.push_back(nx);
    tag_q.push_back(tag);
    check_ports(tag);
  endtask

  initial begin
    for (int i = 0; i < S; i++) m_otp[i] = 0;
    exp_q.push_back(16'h0); tag_q.push_back("R3 first response");
    #100; rst_n = 1'b1; #80;
    check_ports("R3 reset");
    send("R3 ctrl read", 4'd8, 10'h0);
    send("R7 nop", 4'd0, 10'h0);
    send("R2 locked write", 4'd1, 10'h155);
    send("R4 ctrl all", 4'd7, 10'h00F);
    send("R4 ctrl read", 4'd8, 10'h0);
    send("R7 nop after ctrl", 4'd0, 10'h0);
    send("R4 ctrl wr only", 4'd7, 10'h002);
    send("R1 quarter", 4'd1, 10'h100);
    send("R6 wiper read", 4'd2, 10'h0);
    send("R5 store disabled", 4'd3, 10'h0);
    send("R6 last empty", 4'd6, 10'h0);
    send("R4 ctrl prog", 4'd7, 10'h003);
    for (int k = 0; k < S; k++) begin
      send("R1 fill write", 4'd1, 10'(k * 97 + 5));
      send("R5 store", 4'd3, 10'h0);
      send("R5 ctrl after store", 4'd8, 10'h0);
    end
    send("R5 store full", 4'd3, 10'h0);
    send("R5 ctrl after full", 4'd8, 10'h0);
    send("R6 slot read", 4'd5, 10'd1);
    send("R6 slot out of range", 4'd5, 10'd9);
    send("R6 last addr", 4'd6, 10'h0);
    send("R7 write prepares zero", 4'd1, 10'h0AA);
    send("R8 sleep", 4'd9, 10'h001);
    send("R12 write asleep", 4'd1, 10'h2AA);
    send("R12 ctrl read asleep", 4'd8, 10'h0);
    send("R8 wake", 4'd9, 10'h000);
    send("R8 sleep again", 4'd9, 10'h001);
    send("R9 reload", 4'd4, 10'h0);
    send("R9 ctrl kept", 4'd8, 10'h0);
    send("R6 wiper read", 4'd2, 10'h0);
    shift({16'h0, 16'h0411}, 15);
    check_ports("R10 short frame");
    shift({15'h0, 1'b1, 16'h0411}, 17);
    check_ports("R10 long frame");
    send("R10 response kept", 4'd0, 10'h0);
    send("R7 nop tail", 4'd0, 10'h0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule